// File: doc/BRIEF.md
# Reloading Interval Timer Channel

This block is a single timer channel that repeatedly counts down from a period value and reloads itself. Every time the count wraps, it emits a one-cycle interrupt pulse and inverts its output pin, which produces a square wave. The count advances only on a count-clock enable strobe. A mode bit picks one of two such strobes, and a prescaler outside this block generates both of them.

Software controls the channel through write strobes. These cover the period value, a mode word, start and stop triggers, and a software-driven output level. The mode word holds a start-time interrupt bit and a clock-select bit. The triggers are one-cycle write strobes, so they clear themselves and never read back as set. The output-enable input decides who owns the pin: software, or the timer's toggles.

A small state machine sequences the channel. `ST_IDLE` means stopped. `ST_ARMED` means started and waiting for the first selected tick. `ST_COUNT` means counting. The transitions are as follows:
- Start moves the channel from any state to `ST_ARMED`.
- Stop moves it from any state to `ST_IDLE`, and stop has priority over start.
- In `ST_ARMED`, the first selected tick loads the period and moves the channel to `ST_COUNT`.
- `ST_COUNT` stays in place, decrementing on each tick and reloading when the count wraps.

Top module: `interval_timer_ch`

## Requirements
- R1: In `ST_COUNT`, each selected tick decrements `count` by one when it is non-zero. When `count` is zero, the tick loads `period` into `count` instead.
- R2: Every reload from zero drives `irq` high for exactly the following cycle. If `out_en` is 1 on that same cycle, `tout` inverts.
- R3: After a `start_wr` pulse without `stop_wr`, `running` is 1 from the next cycle. The first selected tick after that cycle loads `period` into `count`.
- R4: With the start-interrupt mode bit at 1, the load at start also pulses `irq` and toggles `tout`. With the bit at 0, the load at start does neither.
- R5: After `stop_wr`, `running` is 0 from the next cycle. `count` and `tout` then hold their values while the channel stays stopped.
- R6: If `start_wr` and `stop_wr` are high on the same cycle, the stop takes effect. A start while the channel is running re-arms it, so the next selected tick reloads `period`.
- R7: A `period_wr` while the channel is running does not alter `count`. The new value is used at the next reload.
- R8: A `mode_wr` is accepted only while the channel is stopped. At any other time it has no effect.
- R9: While `out_en` is 0, `lvl_wr` sets `tout` to `lvl_wdata` on the next cycle, and timer toggles are ignored. While `out_en` is 1, `lvl_wr` is ignored.
- R10: A clock-select bit of 0 counts on `tick_a`, and a clock-select bit of 1 counts on `tick_b`.
- R11: After reset, `count` is 0, `running` is 0, `irq` is 0 and `tout` is 0. Both mode bits are also 0.
- R12: In steady counting, successive `irq` pulses are (period + 1) selected ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count-clock enable strobe, selected when the clock-select bit is 0 |
| tick_b | input | 1 | Count-clock enable strobe, selected when the clock-select bit is 1 |
| period_wr | input | 1 | Write strobe for the period register |
| period_wdata | input | W | New period value |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_start_irq | input | 1 | Mode bit: interrupt and toggle on the start load |
| mode_clk_sel | input | 1 | Mode bit: count-clock select |
| start_wr | input | 1 | Start trigger (one-cycle strobe) |
| stop_wr | input | 1 | Stop trigger (one-cycle strobe) |
| out_en | input | 1 | Output enable; 1 gives the pin to the timer |
| lvl_wr | input | 1 | Write strobe for the software output level |
| lvl_wdata | input | 1 | Software output level |
| count | output | W | Current counter value |
| running | output | 1 | Channel started flag |
| irq | output | 1 | One-cycle interrupt pulse |
| tout | output | 1 | Timer output level |

## Verification
The hardest case to reach is a trigger that lands on the same cycle as a selected tick. Examples are a restart while the count is at zero, or a stop arriving together with the arming tick. This case is hard because the ticks come from a free-running divider that software does not see. The stimulus runs the ticks on a fixed divider and places start and stop pulses at every phase offset against that divider. A behavioural model, compared every cycle, confirms that the trigger wins and that no reload or toggle slips through.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } itmr_state_e;
endpackage

// File: rtl/itmr_fsm.sv
module itmr_fsm
    import itmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_wr,
    input  logic        stop_wr,
    input  logic        tick,
    output itmr_state_e state
);
    itmr_state_e state_nxt;

    // Next-state logic: stop beats start, start re-arms from any state.
    always_comb begin
        state_nxt = state;
        if (stop_wr) begin
            state_nxt = ST_IDLE;
        end else if (start_wr) begin
            state_nxt = ST_ARMED;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_ARMED: if (tick) state_nxt = ST_COUNT;
                ST_COUNT: state_nxt = ST_COUNT;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && stop_wr) |=> (state == ST_IDLE)); // R6

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !stop_wr) |=> (state == ST_ARMED)); // R3
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  itmr_state_e   state,
    input  logic          tick,
    input  logic          hold,
    input  logic [W-1:0]  period,
    output logic [W-1:0]  cnt,
    output logic          load_start,
    output logic          load_wrap
);
    logic step;

    assign step       = !hold && tick;
    assign load_start = step && (state == ST_ARMED);
    assign load_wrap  = step && (state == ST_COUNT) && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_start || load_wrap) begin
            cnt <= period;
        end else if (step && (state == ST_COUNT)) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state == ST_COUNT && cnt != '0) |=> (cnt == W'($past(cnt) - 1'b1))); // R1

    AST_WRAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load_wrap |=> (cnt == $past(period))); // R7
endmodule

// File: rtl/interval_timer_ch.sv
module interval_timer_ch
    import itmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_a,
    input  logic          tick_b,
    input  logic          period_wr,
    input  logic [W-1:0]  period_wdata,
    input  logic          mode_wr,
    input  logic          mode_start_irq,
    input  logic          mode_clk_sel,
    input  logic          start_wr,
    input  logic          stop_wr,
    input  logic          out_en,
    input  logic          lvl_wr,
    input  logic          lvl_wdata,
    output logic [W-1:0]  count,
    output logic          running,
    output logic          irq,
    output logic          tout
);
    itmr_state_e  state;
    logic [W-1:0] period_q;
    logic         mode_irq_q;
    logic         mode_sel_q;
    logic         tick_sel;
    logic         hold;
    logic         load_start;
    logic         load_wrap;
    logic         toggle_evt;

    assign tick_sel   = mode_sel_q ? tick_b : tick_a;
    assign hold       = start_wr | stop_wr;
    assign toggle_evt = load_wrap | (load_start & mode_irq_q);

    itmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .stop_wr  (stop_wr),
        .tick     (tick_sel),
        .state    (state)
    );

    itmr_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .tick       (tick_sel),
        .hold       (hold),
        .period     (period_q),
        .cnt        (count),
        .load_start (load_start),
        .load_wrap  (load_wrap)
    );

    // Configuration registers: period is live, mode is locked while running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q   <= '0;
            mode_irq_q <= 1'b0;
            mode_sel_q <= 1'b0;
        end else begin
            if (period_wr) period_q <= period_wdata;
            if (mode_wr && state == ST_IDLE) begin
                mode_irq_q <= mode_start_irq;
                mode_sel_q <= mode_clk_sel;
            end
        end
    end

    // Output process: interrupt pulse and pin level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            tout <= 1'b0;
        end else begin
            irq <= toggle_evt;
            if (!out_en) begin
                if (lvl_wr) tout <= lvl_wdata;
            end else if (toggle_evt) begin
                tout <= ~tout;
            end
        end
    end

    assign running = (state != ST_IDLE);

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(count)); // R5

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(mode_irq_q) && $stable(mode_sel_q))); // R8

    AST_PIN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_en) && !irq) |-> $stable(tout)); // R9

    AST_IRQ_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(out_en)) |-> (tout != $past(tout))); // R2
endmodule

// File: tb/interval_timer_ch_tb.sv
module interval_timer_ch_tb;
    localparam int W      = 16;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_a = 1'b0, tick_b = 1'b0;
    logic         period_wr = 1'b0, mode_wr = 1'b0;
    logic [W-1:0] period_wdata = '0;
    logic         mode_start_irq = 1'b0, mode_clk_sel = 1'b0;
    logic         start_wr = 1'b0, stop_wr = 1'b0;
    logic         out_en = 1'b0, lvl_wr = 1'b0, lvl_wdata = 1'b0;
    logic [W-1:0] count;
    logic         running, irq, tout;

    interval_timer_ch #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .period_wr(period_wr), .period_wdata(period_wdata),
        .mode_wr(mode_wr), .mode_start_irq(mode_start_irq), .mode_clk_sel(mode_clk_sel),
        .start_wr(start_wr), .stop_wr(stop_wr), .out_en(out_en),
        .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
        .count(count), .running(running), .irq(irq), .tout(tout)
    );

    always #(CLK_NS/2) clk = ~clk;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    int    div_a = 1, div_b = 3;
    bit    cmp_on = 0, done = 0;
    string tag = "R11";

    // Behavioural reference model
    int m_st = 0, m_cnt = 0, m_per = 0;
    bit m_irq = 0, m_tout = 0, m_mi = 0, m_ms = 0;
    int last_irq = -1, gap_exp = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit tk, tog;
        int st0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = 0; m_irq = 0; m_tout = 0; m_mi = 0; m_ms = 0;
        end else begin
            tk = m_ms ? tick_b : tick_a;
            tog = 0; st0 = m_st;
            if (stop_wr) m_st = 0;
            else if (start_wr) m_st = 1;
            else if (m_st == 1 && tk) begin
                m_cnt = m_per; m_st = 2; tog = m_mi;
            end else if (m_st == 2 && tk) begin
                if (m_cnt == 0) begin m_cnt = m_per; tog = 1; end
                else m_cnt = m_cnt - 1;
            end
            m_irq = tog;
            if (!out_en) begin
                if (lvl_wr) m_tout = lvl_wdata;
            end else if (tog) m_tout = !m_tout;
            if (period_wr) m_per = int'(period_wdata);
            if (mode_wr && st0 == 0) begin m_mi = mode_start_irq; m_ms = mode_clk_sel; end
        end
    end

    // Tick generators and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        tick_a = (cyc % div_a) == 0;
        tick_b = (cyc % div_b) == 0;
        if (cmp_on) begin
            chk(int'(count) == m_cnt, {tag, " R1 count"}, int'(count), m_cnt);
            chk(running == (m_st != 0), {tag, " R3 running"}, running, m_st != 0);
            chk(irq == m_irq, {tag, " R2 irq"}, irq, m_irq);
            chk(tout == m_tout, {tag, " R9 tout"}, tout, m_tout);
            if (irq) begin
                if (gap_exp > 0 && last_irq >= 0)
                    chk(cyc - last_irq == gap_exp, "R12 irq spacing", cyc - last_irq, gap_exp);
                last_irq = cyc;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(bit also_stop);
        @(negedge clk); start_wr = 1; stop_wr = also_stop;
        @(negedge clk); start_wr = 0; stop_wr = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_wr = 1;
        @(negedge clk); stop_wr = 0;
    endtask

    task automatic set_period(int p);
        @(negedge clk); period_wr = 1; period_wdata = W'(p);
        @(negedge clk); period_wr = 0;
    endtask

    task automatic set_mode(bit mi, bit ms);
        @(negedge clk); mode_wr = 1; mode_start_irq = mi; mode_clk_sel = ms;
        @(negedge clk); mode_wr = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R11: reset values
        chk(count == 0, "R11 count", int'(count), 0);
        chk(running == 0, "R11 running", running, 0);
        chk(irq == 0, "R11 irq", irq, 0);
        chk(tout == 0, "R11 tout", tout, 0);
        cmp_on = 1;

        // R1 R2 R12: basic reload with tick every cycle, period 3 -> gap 4
        tag = "R1"; out_en = 1;
        set_period(3); pulse_start(0);
        gap_exp = 4; idle(30);
        gap_exp = 0;

        // R7: period rewrite while running
        tag = "R7"; set_period(5); idle(30);
        gap_exp = 6; last_irq = -1; idle(20); gap_exp = 0;

        // R8: mode write while running ignored
        tag = "R8"; set_mode(1, 1); idle(15);

        // R5: stop holds count and output
        tag = "R5"; pulse_stop(); idle(12);
        chk(running == 0, "R5 stopped", running, 0);

        // R4 R10: start interrupt mode on, tick_b selected
        tag = "R4"; set_mode(1, 1); set_period(2);
        pulse_start(0); idle(40);
        tag = "R10"; pulse_stop(); set_mode(0, 0); div_a = 2;
        pulse_start(0); idle(30);

        // R6: start+stop together at several tick phases, restart while running
        tag = "R6";
        for (int k = 0; k < 4; k++) begin
            pulse_start(1); idle(k);
            chk(running == 0, "R6 stop wins", running, 0);
            pulse_start(0); idle(5 + k);
            pulse_start(0); idle(k + 3);
        end

        // R9: software level ownership
        tag = "R9"; out_en = 0;
        @(negedge clk); lvl_wr = 1; lvl_wdata = ~tout;
        @(negedge clk); lvl_wr = 0; idle(20);
        out_en = 1;
        @(negedge clk); lvl_wr = 1; lvl_wdata = ~tout;
        @(negedge clk); lvl_wr = 0; idle(20);
        pulse_stop(); idle(4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule